// File: doc/BRIEF.md
# Trip-Threshold Programming Sequence Detector

This block watches the pins of a supply supervisor for the special pin combinations that reprogram its reset trip threshold. Its inputs are already synchronised: the logic levels of chip select, write protect and serial clock, plus two flags from an external detector. One flag says that a high programming voltage is present on the serial clock pin. The other says the same for the serial data pin. When it recognises a valid sequence, the block emits a one-cycle command. A "set" command raises the threshold to the level currently applied. A "reset" command returns the threshold to its native level, which lies below about 1.7 V.

Which command is meant depends on which pins carry the programming voltage. Voltage on both serial pins means set. Voltage on serial data only, with serial clock held at a normal high level, means reset. In both cases write protect must be high, and chip select must make a full low-then-high pulse. The command fires when chip select rises again. The block keeps a "raised" flag so that the order of operations is enforced: a set may only raise the threshold. An external comparator drives the "request below current" input. A set that would lower the threshold while the threshold is raised is refused and flagged as an error.

Top module: `trip_prog_detect`

## Requirements
- R1: While reset is asserted and in the first cycle after it, setCmd, resetCmd and orderErr are 0, and thrRaised is 0.
- R2: A set is recognised when wpHigh=1, hvOnSck=1 and hvOnSi=1 throughout a chip-select low period. In that case setCmd is 1 for one cycle, starting in the cycle after the clock edge at which csHigh is first sampled 1 again, and thrRaised becomes 1 at that same edge. The level of sckHigh is ignored in this mode.
- R3: A reset is recognised when wpHigh=1, sckHigh=1, hvOnSck=0 and hvOnSi=1 throughout a chip-select low period. In that case resetCmd pulses on the same timing as in R2, and thrRaised becomes 0.
- R4: A chip-select pulse with no command is given in any of these cases: wpHigh=0; programming voltage on the serial clock pin only; or the reset pattern with sckHigh=0. thrRaised is then unchanged.
- R5: If the recognised pin pattern changes on any sampled cycle while chip select is low, the sequence is aborted. No command and no error follow its rising edge, and thrRaised is unchanged.
- R6: A recognised set with reqBelow=1 while thrRaised=1 gives orderErr for one cycle instead of setCmd, and thrRaised stays 1.
- R7: A recognised set with reqBelow=1 while thrRaised=0 (native level) is accepted and gives setCmd.
- R8: After reset, chip select must be sampled high before a low period counts. A low period that is already under way when reset is released yields no command.
- R9: A chip-select low period shorter than MinLowCycles sampled cycles yields no command. The default of MinLowCycles is 2.
- R10: setCmd, resetCmd and orderErr are each single-cycle pulses, and no two of them are high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csHigh | input | 1 | Chip select pin level, 1 = high (deselected) |
| wpHigh | input | 1 | Write protect pin level, 1 = high |
| sckHigh | input | 1 | Serial clock pin normal logic level, 1 = high |
| hvOnSck | input | 1 | Programming voltage present on serial clock pin |
| hvOnSi | input | 1 | Programming voltage present on serial data pin |
| reqBelow | input | 1 | Requested threshold is below the current setting |
| setCmd | output | 1 | One-cycle command: store applied level as threshold |
| resetCmd | output | 1 | One-cycle command: return threshold to native level |
| orderErr | output | 1 | One-cycle flag: refused attempt to lower by set |
| thrRaised | output | 1 | Threshold currently above native level |

## Verification
Most internal faults become visible at the ports one cycle after chip select rises. A wrongly captured mode, or a missed abort, shows as the wrong command pulse or a missing one. The raised flag can also hold a stale value, and this may stay hidden until a later sequence. It shows when a set with reqBelow asserted produces an error where a command was due, or a command where an error was due. For that reason the vectors chain sets, resets and refused sets one after another. The short-pulse and abort cases are followed by a valid sequence, so that the bench confirms the detector returns to its idle state.

// File: rtl/trip_prog_pkg.sv
package trip_prog_pkg;

  typedef enum logic [1:0] {
    MODE_NONE  = 2'd0,
    MODE_SET   = 2'd1,
    MODE_RESET = 2'd2
  } progMode_t;

  typedef enum logic [1:0] {
    ST_WAIT_HIGH = 2'd0,
    ST_IDLE      = 2'd1,
    ST_LOW       = 2'd2
  } seqState_t;

  // strobes from sequence control to the datapath
  typedef struct packed {
    logic capture;  // first low cycle: latch the current pin pattern
    logic abort;    // pattern moved during the low period
    logic fire;     // valid rising edge of chip select
  } seqStrobe_t;

endpackage

// File: rtl/trip_prog_ctrl.sv
module trip_prog_ctrl
  import trip_prog_pkg::*;
#(
  parameter int MinLowCycles = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       csHigh,
  input  logic       modeMismatch,
  output seqStrobe_t strobe
);

  localparam int CntW = $clog2(MinLowCycles + 1);
  localparam logic [CntW-1:0] CntMax = CntW'(MinLowCycles);

  seqState_t state, stateNext;
  logic [CntW-1:0] lowCnt;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_WAIT_HIGH: if (csHigh) stateNext = ST_IDLE;
      ST_IDLE: begin
        if (!csHigh) begin
          strobe.capture = 1'b1;
          stateNext      = ST_LOW;
        end
      end
      ST_LOW: begin
        if (csHigh) begin
          strobe.fire = (lowCnt >= CntMax);
          stateNext   = ST_IDLE;
        end else if (modeMismatch) begin
          strobe.abort = 1'b1;
        end
      end
      default: stateNext = ST_WAIT_HIGH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_WAIT_HIGH;
      lowCnt <= '0;
    end else begin
      state <= stateNext;
      if (strobe.capture) begin
        lowCnt <= CntW'(1);
      end else if (state == ST_LOW && !csHigh && lowCnt < CntMax) begin
        lowCnt <= lowCnt + CntW'(1);
      end
    end
  end

endmodule

// File: rtl/trip_prog_dp.sv
module trip_prog_dp
  import trip_prog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wpHigh,
  input  logic       sckHigh,
  input  logic       hvOnSck,
  input  logic       hvOnSi,
  input  logic       reqBelow,
  input  seqStrobe_t strobe,
  output logic       modeMismatch,
  output logic       setCmd,
  output logic       resetCmd,
  output logic       orderErr,
  output logic       thrRaised
);

  progMode_t modeNow, capMode;

  // classify the present pin pattern
  always_comb begin
    modeNow = MODE_NONE;
    if (wpHigh && hvOnSi) begin
      if (hvOnSck)      modeNow = MODE_SET;
      else if (sckHigh) modeNow = MODE_RESET;
    end
  end

  assign modeMismatch = (modeNow != capMode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      capMode   <= MODE_NONE;
      setCmd    <= 1'b0;
      resetCmd  <= 1'b0;
      orderErr  <= 1'b0;
      thrRaised <= 1'b0;
    end else begin
      setCmd   <= 1'b0;
      resetCmd <= 1'b0;
      orderErr <= 1'b0;
      if (strobe.capture)    capMode <= modeNow;
      else if (strobe.abort) capMode <= MODE_NONE;
      if (strobe.fire) begin
        unique case (capMode)
          MODE_SET: begin
            if (reqBelow && thrRaised) begin
              orderErr <= 1'b1;
            end else begin
              setCmd    <= 1'b1;
              thrRaised <= 1'b1;
            end
          end
          MODE_RESET: begin
            resetCmd  <= 1'b1;
            thrRaised <= 1'b0;
          end
          default: ;
        endcase
        capMode <= MODE_NONE;
      end
    end
  end

endmodule

// File: rtl/trip_prog_detect.sv
module trip_prog_detect
  import trip_prog_pkg::*;
#(
  parameter int MinLowCycles = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic csHigh,
  input  logic wpHigh,
  input  logic sckHigh,
  input  logic hvOnSck,
  input  logic hvOnSi,
  input  logic reqBelow,
  output logic setCmd,
  output logic resetCmd,
  output logic orderErr,
  output logic thrRaised
);

  seqStrobe_t strobe;
  logic       modeMismatch;

  trip_prog_ctrl #(.MinLowCycles(MinLowCycles)) ctrl_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .csHigh       (csHigh),
    .modeMismatch (modeMismatch),
    .strobe       (strobe)
  );

  trip_prog_dp dp_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .wpHigh       (wpHigh),
    .sckHigh      (sckHigh),
    .hvOnSck      (hvOnSck),
    .hvOnSi       (hvOnSi),
    .reqBelow     (reqBelow),
    .strobe       (strobe),
    .modeMismatch (modeMismatch),
    .setCmd       (setCmd),
    .resetCmd     (resetCmd),
    .orderErr     (orderErr),
    .thrRaised    (thrRaised)
  );

endmodule

// File: rtl/trip_prog_chk.sv
module trip_prog_chk (
  input logic clk,
  input logic rst_n,
  input logic csHigh,
  input logic setCmd,
  input logic resetCmd,
  input logic orderErr,
  input logic thrRaised
);

  // R10
  cmd_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({setCmd, resetCmd, orderErr}) <= 1);

  // R10
  set_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    setCmd |=> !setCmd);

  // R10
  reset_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resetCmd |=> !resetCmd);

  // R2
  set_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
    setCmd |-> thrRaised);

  // R3
  reset_lowers_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resetCmd |-> !thrRaised);

  // R2
  raise_needs_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(thrRaised) |-> setCmd);

  // R3
  lower_needs_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(thrRaised) |-> resetCmd);

  // R6
  err_keeps_raised_chk: assert property (@(posedge clk) disable iff (!rst_n)
    orderErr |-> (thrRaised && $stable(thrRaised)));

  // R2
  cmd_after_cs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (setCmd || resetCmd) |-> $past(csHigh));

endmodule

bind trip_prog_detect trip_prog_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .csHigh    (csHigh),
  .setCmd    (setCmd),
  .resetCmd  (resetCmd),
  .orderErr  (orderErr),
  .thrRaised (thrRaised)
);

// File: tb/trip_prog_detect_tb_top.sv
`timescale 1ns/1ps
module trip_prog_detect_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csHigh = 1'b0, wpHigh = 1'b0, sckHigh = 1'b0;
  logic hvOnSck = 1'b0, hvOnSi = 1'b0, reqBelow = 1'b0;
  logic setCmd, resetCmd, orderErr, thrRaised;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  trip_prog_detect #(.MinLowCycles(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .csHigh(csHigh), .wpHigh(wpHigh),
    .sckHigh(sckHigh), .hvOnSck(hvOnSck), .hvOnSi(hvOnSi),
    .reqBelow(reqBelow), .setCmd(setCmd), .resetCmd(resetCmd),
    .orderErr(orderErr), .thrRaised(thrRaised)
  );

  // {wp, sck, hvSck, hvSi, reqBelow}_{lowCycles}_{expSet, expRst, expErr, expRaised}
  localparam int NVec = 10;
  localparam logic [12:0] VECS [NVec] = '{
    13'b10110_0010_1001,  // R2 set from native
    13'b10111_0010_0011,  // R6 lowering set refused
    13'b10110_0011_1001,  // R2 set, longer low
    13'b00110_0010_0001,  // R4 write protect low
    13'b11010_0010_0100,  // R3 reset to native
    13'b10111_0010_1001,  // R7 reqBelow allowed at native
    13'b11100_0010_0001,  // R4 voltage on clock only
    13'b10010_0010_0001,  // R4 reset pattern with clock low
    13'b11010_0100_0100,  // R3 reset, long low
    13'b11110_0010_1001   // R2 clock level ignored in set mode
  };

  task automatic check(input string req, input string what, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic checkOut(input string req, input logic eS, input logic eR,
                          input logic eE, input logic eRaised);
    check(req, "setCmd", setCmd, eS);
    check(req, "resetCmd", resetCmd, eR);
    check(req, "orderErr", orderErr, eE);
    check(req, "thrRaised", thrRaised, eRaised);
  endtask

  // drive pins at negedge, then pulse chip select low for n sampled cycles
  task automatic csPulse(input logic [4:0] pins, input int n);
    @(negedge clk);
    {wpHigh, sckHigh, hvOnSck, hvOnSi, reqBelow} = pins;
    csHigh = 1'b1;
    @(negedge clk);
    csHigh = 1'b0;
    for (int i = 0; i < n; i++) @(negedge clk);
    csHigh = 1'b1;
    @(negedge clk);  // pulse visible here
  endtask

  initial begin
    #(4 * 20000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    // R8: chip select low with set pattern during and after reset
    {wpHigh, sckHigh, hvOnSck, hvOnSi, reqBelow} = 5'b10110;
    csHigh = 1'b0;
    repeat (3) @(negedge clk);
    checkOut("R1", 1'b0, 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    checkOut("R1", 1'b0, 1'b0, 1'b0, 1'b0);
    repeat (2) @(negedge clk);
    csHigh = 1'b1;
    @(negedge clk);
    check("R8", "setCmd", setCmd, 1'b0);
    check("R8", "thrRaised", thrRaised, 1'b0);

    for (int v = 0; v < NVec; v++) begin
      logic [12:0] vec;
      vec = VECS[v];
      csPulse(vec[12:8], int'(vec[7:4]));
      checkOut($sformatf("vector %0d", v), vec[3], vec[2], vec[1], vec[0]);
      @(negedge clk);
      check("R10", "setCmd gone", setCmd, 1'b0);
      check("R10", "resetCmd gone", resetCmd, 1'b0);
      check("R10", "orderErr gone", orderErr, 1'b0);
    end

    // R9: short low period (1 cycle) with reset pattern; raised stays 1
    csPulse(5'b11010, 1);
    checkOut("R9", 1'b0, 1'b0, 1'b0, 1'b1);

    // R5: reset pattern, then clock pin gets programming voltage mid-pulse
    @(negedge clk);
    {wpHigh, sckHigh, hvOnSck, hvOnSi, reqBelow} = 5'b11010;
    csHigh = 1'b1;
    @(negedge clk);
    csHigh = 1'b0;
    @(negedge clk);
    hvOnSck = 1'b1;
    @(negedge clk);
    hvOnSck = 1'b0;
    @(negedge clk);
    csHigh = 1'b1;
    @(negedge clk);
    checkOut("R5", 1'b0, 1'b0, 1'b0, 1'b1);

    // recovery after abort: valid reset works
    csPulse(5'b11010, 2);
    checkOut("R3", 1'b0, 1'b1, 1'b0, 1'b0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule